// File: doc/BRIEF.md
# Frequency-Domain Channel Bin Combiner

This block applies a time-varying radio channel to signals that have already been moved into the frequency domain. For every frequency bin it takes one transformed sample from each transmit input, weights it by the complex channel frequency response stored for that input and that bin, adds the weighted contributions together and hands one receive-output bin value to the inverse transform. The sum is saturated and cut down to the width of the output converter.

Responses live in an on-chip profile memory that holds a finite set of recorded profiles. A sequencer keeps one profile active for a programmable number of frames, then moves to the next one. After the last profile of the configured set it returns to the first, so the recording is replayed in a loop. Profile changes only happen at a frame start, so every bin in a frame sees the same channel snapshot. The profile memory is filled through a simple write port.

Top module: `bcmb_top`

## Requirements
- R1: For each valid beat, each complex output equals the sum over both transmit inputs of the input sample times the stored response for (active profile, that input, current bin), after the processing of R2 and R3.
- R2: Responses are signed Q1.15 values. Each complex product term is rounded on its own to the input scale, before the terms are summed. The real part is round((xr*hr - xi*hi)/2^15) and the imaginary part is round((xr*hi + xi*hr)/2^15). Halves round upward, so the rule is floor((p + 2^14)/2^15).
- R3: The summed value is saturated to the signed 16-bit range [-32768, 32767]. Its two least significant bits are then dropped by an arithmetic shift right by 2, which gives a signed 14-bit output.
- R4: The bin index is 0 on any valid beat with `in_sof` high. It increases by one on each later valid beat and wraps at NBINS. Beats with `in_valid` low do not advance it. A new `in_sof` restarts the index even if the frame was short.
- R5: `out_valid` and `out_sof` follow `in_valid` and `in_valid && in_sof` by exactly three clock cycles. Outputs appear in input order, and `out_sof` is never high without `out_valid`.
- R6: The active profile changes only on a valid beat with `in_sof` high. All beats of one frame use the same profile.
- R7: Frames are counted from the first frame after reset, starting at index 0. Frame k uses profile floor(k / P) mod N, where P is `cfg_period` (0 acts as 1).
- R8: N is `cfg_nprof`, where 0 acts as 1 and values above NPROF act as NPROF. After profile N-1 the sequence returns to profile 0.
- R9: While reset is held, `out_valid`, `out_sof`, `out_re` and `out_im` are 0. After reset, the sequencer restarts with frame index 0.
- R10: A write with `wr_en` high stores {`wr_re`,`wr_im`} for (`wr_prof`, `wr_tx`, `wr_bin`). Every beat that reads that entry later uses the new value. Profile memory contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | PERW | Frames per profile (0 treated as 1) |
| cfg_nprof | input | clog2(NPROF+1) | Profiles in the replayed set |
| wr_en | input | 1 | Response write strobe |
| wr_prof | input | clog2(NPROF) | Profile written |
| wr_tx | input | 1 | Transmit input written |
| wr_bin | input | clog2(NBINS) | Bin written |
| wr_re | input | CW | Response real part |
| wr_im | input | CW | Response imaginary part |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | Beat is bin 0 of a frame |
| in_re | input | NTX*DW | Real parts, input 0 in the low slice |
| in_im | input | NTX*DW | Imaginary parts, input 0 in the low slice |
| out_valid | output | 1 | Output beat valid |
| out_sof | output | 1 | Output beat is bin 0 |
| out_re | output | OW | Output real part |
| out_im | output | OW | Output imaginary part |

## Verification
If the bin counter or the profile pointer holds a wrong value, the block reads the wrong memory entry. The error shows up on `out_re`/`out_im` three cycles after the affected input beat. A profile pointer error lasts for the whole frame and every frame after it, until the sequence wraps. A bin counter error shows up within the same frame and lasts until the next `in_sof`. The bench loads every profile, bin and input with a distinct response, so a wrong entry almost always changes the value. It sweeps short frames, idle gaps and clamped configuration values, and it checks the rounding and saturation points with values chosen to land on them.

// File: rtl/bcmb_pkg.sv
package bcmb_pkg;

  typedef logic signed [63:0] wide_t;

  // round((a*c -/+ b*d) / 2^frac), ties toward +inf
  function automatic wide_t cplx_term(input wide_t a, input wide_t b,
                                      input wide_t c, input wide_t d,
                                      input bit sub, input int unsigned frac);
    wide_t acc;
    acc = sub ? (a * c - b * d) : (a * c + b * d);
    return (acc + (64'sd1 <<< (frac - 1))) >>> frac;
  endfunction

  // clamp v to a signed iw-bit range, then keep the top ow bits
  function automatic wide_t sat_drop(input wide_t v, input int unsigned iw,
                                     input int unsigned ow);
    wide_t hi;
    wide_t lo;
    wide_t c;
    hi = (64'sd1 <<< (iw - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    c  = (v > hi) ? hi : ((v < lo) ? lo : v);
    return c >>> (iw - ow);
  endfunction

endpackage

// File: rtl/bcmb_bank.sv
module bcmb_bank #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int WW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/bcmb_seq.sv
module bcmb_seq #(
  parameter int NBINS = 64,
  parameter int NPROF = 4,
  parameter int PERW  = 16,
  localparam int BW   = $clog2(NBINS),
  localparam int PIW  = $clog2(NPROF),
  localparam int NPW  = $clog2(NPROF + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sof,
  input  logic [PERW-1:0] cfg_period,
  input  logic [NPW-1:0]  cfg_nprof,
  output logic [PIW-1:0]  rd_prof,
  output logic [BW-1:0]   rd_bin
);

  logic [BW-1:0]   bin_cnt;
  logic [PIW-1:0]  cur_prof;
  logic [PERW-1:0] frm_cnt;
  logic            started;

  logic [PERW-1:0] eff_per;
  logic [NPW-1:0]  eff_np;
  logic            ev_frame;
  logic            ev_adv;
  logic            ev_last;
  logic [PIW-1:0]  next_prof;

  always_comb begin
    eff_per   = (cfg_period == '0) ? PERW'(1) : cfg_period;
    if (cfg_nprof == '0)                eff_np = NPW'(1);
    else if (cfg_nprof > NPW'(NPROF))   eff_np = NPW'(NPROF);
    else                                eff_np = cfg_nprof;
    ev_frame  = in_valid && in_sof;
    ev_adv    = ev_frame && started && (frm_cnt >= eff_per);
    ev_last   = (NPW'(cur_prof) + NPW'(1)) >= eff_np;
    if (!started)      next_prof = '0;
    else if (ev_adv)   next_prof = ev_last ? '0 : cur_prof + PIW'(1);
    else               next_prof = cur_prof;
    rd_prof   = ev_frame ? next_prof : cur_prof;
    rd_bin    = ev_frame ? '0 : bin_cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bin_cnt  <= '0;
      cur_prof <= '0;
      frm_cnt  <= '0;
      started  <= 1'b0;
    end else begin
      if (in_valid) bin_cnt <= rd_bin + BW'(1);
      if (ev_frame) begin
        started  <= 1'b1;
        cur_prof <= next_prof;
        frm_cnt  <= (ev_adv || !started) ? PERW'(1) : frm_cnt + PERW'(1);
      end
    end
  end

  AST_PROF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_frame |=> $stable(cur_prof)); // R6
  AST_PROF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |=> NPW'(cur_prof) < $past(eff_np)); // R8
  AST_PROF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_adv && ev_last) |=> cur_prof == '0); // R8
  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame && started) |=> frm_cnt <= $past(eff_per)); // R7

endmodule

// File: rtl/bcmb_cmac.sv
module bcmb_cmac
  import bcmb_pkg::*;
#(
  parameter int NTX = 2,
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int OW  = 14,
  localparam int FRAC = CW - 1,
  localparam int RW   = DW + 2,
  localparam int SW   = RW + $clog2(NTX) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_in,
  input  logic              sof_in,
  input  logic [NTX*DW-1:0] x_re,
  input  logic [NTX*DW-1:0] x_im,
  input  logic [NTX*CW-1:0] h_re,
  input  logic [NTX*CW-1:0] h_im,
  output logic              out_valid,
  output logic              out_sof,
  output logic [OW-1:0]     out_re,
  output logic [OW-1:0]     out_im
);

  localparam logic signed [SW-1:0] MAXV = SW'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

  logic signed [RW-1:0] pr_re [NTX];
  logic signed [RW-1:0] pr_im [NTX];
  logic                 v2;
  logic                 sof2;
  logic signed [SW-1:0] s_re;
  logic signed [SW-1:0] s_im;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2   <= 1'b0;
      sof2 <= 1'b0;
      for (int t = 0; t < NTX; t++) begin
        pr_re[t] <= '0;
        pr_im[t] <= '0;
      end
    end else begin
      v2   <= v_in;
      sof2 <= sof_in;
      if (v_in) begin
        for (int t = 0; t < NTX; t++) begin
          pr_re[t] <= RW'(cplx_term(wide_t'(signed'(x_re[t*DW +: DW])),
                                    wide_t'(signed'(x_im[t*DW +: DW])),
                                    wide_t'(signed'(h_re[t*CW +: CW])),
                                    wide_t'(signed'(h_im[t*CW +: CW])),
                                    1'b1, FRAC));
          pr_im[t] <= RW'(cplx_term(wide_t'(signed'(x_re[t*DW +: DW])),
                                    wide_t'(signed'(x_im[t*DW +: DW])),
                                    wide_t'(signed'(h_im[t*CW +: CW])),
                                    wide_t'(signed'(h_re[t*CW +: CW])),
                                    1'b0, FRAC));
        end
      end
    end
  end

  always_comb begin
    s_re = '0;
    s_im = '0;
    for (int t = 0; t < NTX; t++) begin
      s_re = s_re + SW'(pr_re[t]);
      s_im = s_im + SW'(pr_im[t]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= v2;
      out_sof   <= sof2;
      if (v2) begin
        out_re <= OW'(sat_drop(wide_t'(s_re), DW, OW));
        out_im <= OW'(sat_drop(wide_t'(s_im), DW, OW));
      end
    end
  end

  AST_SOF_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid); // R5
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && s_re > MAXV) |=> out_re == {1'b0, {(OW-1){1'b1}}}); // R3
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (v2 && s_im < MINV) |=> out_im == {1'b1, {(OW-1){1'b0}}}); // R3

endmodule

// File: rtl/bcmb_top.sv
module bcmb_top #(
  parameter int NTX   = 2,
  parameter int NBINS = 64,
  parameter int NPROF = 4,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 14,
  parameter int PERW  = 16,
  localparam int BW    = $clog2(NBINS),
  localparam int PIW   = $clog2(NPROF),
  localparam int NPW   = $clog2(NPROF + 1),
  localparam int TXW   = (NTX > 1) ? $clog2(NTX) : 1,
  localparam int AW    = PIW + BW,
  localparam int DEPTH = NPROF * NBINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PERW-1:0]   cfg_period,
  input  logic [NPW-1:0]    cfg_nprof,
  input  logic              wr_en,
  input  logic [PIW-1:0]    wr_prof,
  input  logic [TXW-1:0]    wr_tx,
  input  logic [BW-1:0]     wr_bin,
  input  logic [CW-1:0]     wr_re,
  input  logic [CW-1:0]     wr_im,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [NTX*DW-1:0] in_re,
  input  logic [NTX*DW-1:0] in_im,
  output logic              out_valid,
  output logic              out_sof,
  output logic [OW-1:0]     out_re,
  output logic [OW-1:0]     out_im
);

  logic [PIW-1:0]    rd_prof;
  logic [BW-1:0]     rd_bin;
  logic              v1;
  logic              sof1;
  logic [NTX*DW-1:0] xr1;
  logic [NTX*DW-1:0] xi1;
  logic [NTX*CW-1:0] h_re;
  logic [NTX*CW-1:0] h_im;

  bcmb_seq #(.NBINS(NBINS), .NPROF(NPROF), .PERW(PERW)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .cfg_period(cfg_period), .cfg_nprof(cfg_nprof),
    .rd_prof(rd_prof), .rd_bin(rd_bin)
  );

  for (genvar b = 0; b < NTX; b++) begin : g_bank
    logic [2*CW-1:0] rdata;
    bcmb_bank #(.DEPTH(DEPTH), .AW(AW), .WW(2*CW)) u_bank (
      .clk(clk),
      .we(wr_en && (wr_tx == TXW'(b))),
      .waddr({wr_prof, wr_bin}),
      .wdata({wr_re, wr_im}),
      .raddr({rd_prof, rd_bin}),
      .rdata(rdata)
    );
    assign h_re[b*CW +: CW] = rdata[2*CW-1:CW];
    assign h_im[b*CW +: CW] = rdata[CW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      sof1 <= 1'b0;
      xr1  <= '0;
      xi1  <= '0;
    end else begin
      v1   <= in_valid;
      sof1 <= in_valid && in_sof;
      xr1  <= in_re;
      xi1  <= in_im;
    end
  end

  bcmb_cmac #(.NTX(NTX), .DW(DW), .CW(CW), .OW(OW)) u_cmac (
    .clk(clk), .rst_n(rst_n), .v_in(v1), .sof_in(sof1),
    .x_re(xr1), .x_im(xi1), .h_re(h_re), .h_im(h_im),
    .out_valid(out_valid), .out_sof(out_sof),
    .out_re(out_re), .out_im(out_im)
  );

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 3)); // R5
  AST_SOF_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof == $past(in_valid && in_sof, 3)); // R5

endmodule

// File: tb/bcmb_top_bench.sv
module bcmb_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NBINS = 8;
  localparam int NPROF = 4;
  localparam int PERW  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_period = 8'd1;
  logic [2:0]  cfg_nprof = 3'd1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_prof = '0;
  logic        wr_tx = 1'b0;
  logic [2:0]  wr_bin = '0;
  logic [15:0] wr_re = '0;
  logic [15:0] wr_im = '0;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [31:0] in_re = '0;
  logic [31:0] in_im = '0;
  logic        out_valid;
  logic        out_sof;
  logic [13:0] out_re;
  logic [13:0] out_im;

  bcmb_top #(.NBINS(NBINS), .NPROF(NPROF), .PERW(PERW)) u_bcmb_top (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_nprof(cfg_nprof),
    .wr_en(wr_en), .wr_prof(wr_prof), .wr_tx(wr_tx), .wr_bin(wr_bin),
    .wr_re(wr_re), .wr_im(wr_im), .in_valid(in_valid), .in_sof(in_sof),
    .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_sof(out_sof),
    .out_re(out_re), .out_im(out_im)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int     n_checks = 0;
  int     n_fails  = 0;
  longint cyc = 0;
  longint ref_re [NPROF][2][NBINS];
  longint ref_im [NPROF][2][NBINS];
  longint m_pe = 1, m_ne = 1, m_frame = -1, m_bin = 0;

  longint q_re[$];
  longint q_im[$];
  bit     q_sof[$];
  longint q_cyc[$];
  string  q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint fdiv(longint n, longint d);
    if (n >= 0) return n / d;
    return -((-n + d - 1) / d);
  endfunction

  function automatic longint s16(longint v);
    return ((v % 65536) + 65536) % 65536 - 32768;
  endfunction

  function automatic void expect_beat(longint r0, longint i0, longint r1, longint i1,
                                      bit sof, string tag);
    longint p;
    longint er, ei;
    p  = (m_frame / m_pe) % m_ne;
    er = fdiv(r0 * ref_re[p][0][m_bin] - i0 * ref_im[p][0][m_bin] + 16384, 32768)
       + fdiv(r1 * ref_re[p][1][m_bin] - i1 * ref_im[p][1][m_bin] + 16384, 32768);
    ei = fdiv(r0 * ref_im[p][0][m_bin] + i0 * ref_re[p][0][m_bin] + 16384, 32768)
       + fdiv(r1 * ref_im[p][1][m_bin] + i1 * ref_re[p][1][m_bin] + 16384, 32768);
    if (er > 32767) er = 32767;
    if (er < -32768) er = -32768;
    if (ei > 32767) ei = 32767;
    if (ei < -32768) ei = -32768;
    q_re.push_back(fdiv(er, 4));
    q_im.push_back(fdiv(ei, 4));
    q_sof.push_back(sof);
    q_cyc.push_back(cyc + 3);
    q_tag.push_back(tag);
  endfunction

  task automatic beat(input bit v, input bit s, input longint r0, input longint i0,
                      input longint r1, input longint i1, input string tag);
    @(negedge clk);
    in_valid = v;
    in_sof   = s;
    in_re    = {16'(r1), 16'(r0)};
    in_im    = {16'(i1), 16'(i0)};
    if (v) begin
      if (s) begin
        m_frame = m_frame + 1;
        m_bin   = 0;
      end
      expect_beat(r0, i0, r1, i1, s, tag);
      m_bin = (m_bin + 1) % NBINS;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
    end
  endtask

  task automatic wr(input int p, input int t, input int b, input longint re, input longint im);
    @(negedge clk);
    wr_en = 1'b1; wr_prof = 2'(p); wr_tx = 1'(t); wr_bin = 3'(b);
    wr_re = 16'(re); wr_im = 16'(im);
    ref_re[p][t][b] = re;
    ref_im[p][t][b] = im;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input int per, input int np, input longint pe, input longint ne);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sof = 1'b0;
    cfg_period = 8'(per);
    cfg_nprof = 3'(np);
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_re !== '0 || out_im !== '0) begin
      n_fails++;
      $display("FAIL R9 reset outputs actual=%b %b %h %h expected=0 0 0 0",
               out_valid, out_sof, out_re, out_im);
    end
    @(negedge clk);
    rst_n = 1'b1;
    m_pe = pe;
    m_ne = ne;
    m_frame = -1;
    m_bin = 0;
  endtask

  task automatic drain(input string tag);
    idle(6);
    n_checks++;
    if (q_re.size() != 0) begin
      n_fails++;
      $display("FAIL %s R5 missing outputs actual=%0d pending expected=0", tag, q_re.size());
      q_re.delete(); q_im.delete(); q_sof.delete(); q_cyc.delete(); q_tag.delete();
    end
  endtask

  task automatic run_frame(input int len, input bit gaps, input longint seed, input string tag);
    for (int b = 0; b < len; b++) begin
      if (gaps && (b % 3 == 1)) beat(1'b0, 1'b0, 0, 0, 0, 0, tag);
      beat(1'b1, b == 0,
           s16(seed * 131 + m_frame * 977 + b * 4099 + 7),
           s16(seed * 173 + m_frame * 613 + b * 2311 + 23311),
           s16(seed * 197 + m_frame * 389 + b * 6151 + 15013),
           s16(seed * 211 + m_frame * 827 + b * 3571 + 40009), tag);
    end
  endtask

  // output monitor: sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_checks++;
      if (q_re.size() == 0) begin
        n_fails++;
        $display("FAIL R5 unexpected output actual=valid expected=idle");
      end else begin
        longint er, ei, ec;
        bit es;
        string tg;
        er = q_re.pop_front(); ei = q_im.pop_front(); es = q_sof.pop_front();
        ec = q_cyc.pop_front(); tg = q_tag.pop_front();
        if (longint'($signed(out_re)) != er || longint'($signed(out_im)) != ei ||
            out_sof != es || cyc != ec) begin
          n_fails++;
          $display("FAIL %s R1 R5 actual=(%0d,%0d,sof%0b,cyc%0d) expected=(%0d,%0d,sof%0b,cyc%0d)",
                   tg, $signed(out_re), $signed(out_im), out_sof, cyc, er, ei, es, ec);
        end
      end
    end else if (rst_n && out_sof) begin
      n_checks++;
      n_fails++;
      $display("FAIL R5 out_sof without out_valid actual=1 expected=0");
    end
  end

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    do_reset(1, 1, 1, 1);                               // R9
    for (int p = 0; p < NPROF; p++)
      for (int t = 0; t < 2; t++)
        for (int b = 0; b < NBINS; b++)
          wr(p, t, b, s16(p * 7919 + t * 10477 + b * 2713 + 1234),
                      s16(p * 4241 + t * 8887 + b * 5347 + 999));     // R10

    // R1 R7 R8: period 1, four profiles, back-to-back frames
    do_reset(1, 4, 1, 4);
    for (int f = 0; f < 6; f++) run_frame(NBINS, 1'b0, 1, "R1 R7 R8");
    drain("R1");

    // R4 R6: gaps, short frames, period 3 over two profiles
    do_reset(3, 2, 3, 2);
    for (int f = 0; f < 8; f++) run_frame((f % 3 == 2) ? 5 : NBINS, 1'b1, 2, "R4 R6");
    idle(3);
    run_frame(NBINS, 1'b0, 3, "R4");
    drain("R4");

    // R7 R8: zero settings act as one
    do_reset(0, 0, 1, 1);
    for (int f = 0; f < 4; f++) run_frame(NBINS, 1'b0, 4, "R7 R8 zero");
    drain("R7");
    // R8: set size above NPROF clamps to NPROF
    do_reset(2, 7, 2, 4);
    for (int f = 0; f < 10; f++) run_frame(NBINS, 1'b0, 5, "R8 clamp");
    drain("R8");

    // R2 R10: rounding of each product term before summing
    do_reset(1, 1, 1, 1);
    wr(0, 0, 0, 16384, 0);  wr(0, 1, 0, 16384, 0);
    wr(0, 0, 1, 16384, 0);  wr(0, 1, 1, 0, 0);
    wr(0, 0, 2, 0, 16384);  wr(0, 1, 2, 0, -16384);
    wr(0, 0, 3, -16384, 0); wr(0, 1, 3, 16384, 0);
    // R3: extreme responses for saturation
    wr(0, 0, 4, 32767, 0);  wr(0, 1, 4, 32767, 0);
    wr(0, 0, 5, -32768, 0); wr(0, 1, 5, -32768, 0);
    wr(0, 0, 6, 32767, 32767); wr(0, 1, 6, 32767, -32768);
    wr(0, 0, 7, 0, 32767);  wr(0, 1, 7, 0, 32767);
    beat(1'b1, 1'b1, 7, 7, 7, -7, "R2 R10");
    beat(1'b1, 1'b0, 7, -7, 3, 1, "R2");
    beat(1'b1, 1'b0, -7, 9, 5, -5, "R2");
    beat(1'b1, 1'b0, 1, -1, 1, 1, "R2");
    beat(1'b1, 1'b0, 32767, 32767, 32767, -32768, "R3");
    beat(1'b1, 1'b0, 32767, -32768, 32767, 32767, "R3");
    beat(1'b1, 1'b0, -32768, 32767, 32767, -32768, "R3");
    beat(1'b1, 1'b0, 32767, -32768, 32767, -32768, "R3");
    run_frame(NBINS, 1'b0, 6, "R3");
    drain("R2");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule